// File: doc/BRIEF.md
# Dual-Strobe Up/Down Cascadable Counter

This block is a small synchronous counter with two separate direction strobes. One strobe counts up and the other counts down. Each strobe rests high, and the count moves by one on the rising edge of whichever strobe was pulsed low. Both strobes are brought into the system clock domain, and their edges are found with a registered copy of the previous level. A parameter selects the sequence: a decade (0 to 9) sequence or a plain binary (0 to 15) sequence.

Two controls sit above counting. A synchronous active-high clear drives the count to zero. An active-low load copies a 4-bit preset word into the count. Clear wins over load, and load wins over both strobes.

Two active-low terminal outputs let several stages be chained with no glue logic. The carry output feeds the up strobe of the next stage, and the borrow output feeds its down strobe. Carry is low while the count sits at its top value and the up strobe is low. Borrow is low while the count is zero and the down strobe is low. When the strobe rises again, the terminal output rises with it, and that edge steps the next stage.

Top module: `updown_strobe_counter`

## Requirements
- R1: While `rst` is high, and after it is released with both strobes high, `q_o` is 0 and both `carry_n_o` and `borrow_n_o` are 1.
- R2: A rising edge on `cnt_up_i` while `cnt_dn_i` is high adds one to `q_o`. The new value appears on the third rising clock edge after the strobe input rises, counted with two synchronizer stages.
- R3: A rising edge on `cnt_dn_i` while `cnt_up_i` is high subtracts one from `q_o`, with the same latency as R2.
- R4: With `DECADE=1`, an up count from 9 gives 0 and a down count from 0 gives 9.
- R5: With `DECADE=0`, an up count from 15 gives 0 and a down count from 0 gives 15.
- R6: With `DECADE=1`, a preset value from 10 to 15 is loaded unchanged. An up count from any such value gives 0, and a down count from such a value subtracts one.
- R7: While `load_n_i` is 0 and `clear_i` is 0, `q_o` takes `preset_i` at each clock edge, and strobe edges have no effect. `preset_i[0]` is the least significant bit.
- R8: While `clear_i` is 1, `q_o` becomes 0 at the next clock edge, whatever the values of `load_n_i`, `preset_i` and the strobes.
- R9: `carry_n_o` is 0 exactly when `q_o` equals the top value (9 with `DECADE=1`, 15 with `DECADE=0`) and the synchronized `cnt_up_i` is low.
- R10: `borrow_n_o` is 0 exactly when `q_o` is 0 and the synchronized `cnt_dn_i` is low.
- R11: A rising edge on one strobe while the other strobe is low leaves `q_o` unchanged. Rising edges on both strobes in the same cycle also leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_up_i | input | 1 | Up-count strobe, idle high, counts on its rising edge |
| cnt_dn_i | input | 1 | Down-count strobe, idle high, counts on its rising edge |
| load_n_i | input | 1 | Parallel preset enable, active low |
| clear_i | input | 1 | Clear to zero, active high, highest priority |
| preset_i | input | 4 | Preset word, bit 0 is the least significant bit |
| q_o | output | 4 | Current count |
| carry_n_o | output | 1 | Active-low carry toward the next stage |
| borrow_n_o | output | 1 | Active-low borrow toward the next stage |

## Verification
The count register is the whole state, so a wrong next-value choice shows on `q_o` three clock edges after the strobe that caused it, and it stays there until clear or load. A bad edge detector shows as a step that is missed, doubled or made in the wrong direction when a strobe rises while the other strobe is low. A wrong top value or a wrong flag condition shows on `carry_n_o` or `borrow_n_o` two edges after the strobe falls. A fault in the wrap logic shows only at the ends of the range, so the stimulus walks through 9, 15 and 0 and through decade presets above 9.

// File: rtl/updn_pkg.sv
package updn_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_INC  = 2'd1,
    ACT_DEC  = 2'd2
  } step_act_t;

  // Top value of the count sequence for a given width and mode.
  function automatic int unsigned top_code(input int unsigned width, input bit decade);
    return decade ? 9 : ((1 << width) - 1);
  endfunction

endpackage

// File: rtl/updn_strobe_edge.sv
// Brings one idle-high strobe into the clock domain and flags its rising edge.
module updn_strobe_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic level_o,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) begin
          chain_q[s] <= 1'b1;
        end else if (s == 0) begin
          chain_q[s] <= strobe_i;
        end else begin
          chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[SYNC_STAGES-1];
  end

  assign level_o = chain_q[SYNC_STAGES-1];
  assign rise_o  = chain_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/updn_next_value.sv
// Next count value for one step in the selected sequence.
module updn_next_value
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b1
) (
  input  logic [WIDTH-1:0] cur_i,
  input  step_act_t        act_i,
  output logic [WIDTH-1:0] nxt_o
);

  localparam logic [WIDTH-1:0] TOP = WIDTH'(top_code(WIDTH, DECADE));

  logic [WIDTH-1:0] inc_val;

  generate
    if (DECADE) begin : g_dec_inc
      // Reaching or passing the top (presets 10..15) folds back to zero.
      assign inc_val = (cur_i >= TOP) ? '0 : cur_i + 1'b1;
    end else begin : g_bin_inc
      assign inc_val = cur_i + 1'b1;
    end
  endgenerate

  always_comb begin
    case (act_i)
      ACT_INC: nxt_o = inc_val;
      ACT_DEC: nxt_o = (cur_i == '0) ? TOP : cur_i - 1'b1;
      default: nxt_o = cur_i;
    endcase
  end

endmodule

// File: rtl/updn_terminal.sv
// Active-low terminal flags used to chain stages.
module updn_terminal
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b1
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             up_lvl_i,
  input  logic             dn_lvl_i,
  output logic             carry_n_o,
  output logic             borrow_n_o
);

  localparam logic [WIDTH-1:0] TOP = WIDTH'(top_code(WIDTH, DECADE));

  assign carry_n_o  = ~((cnt_i == TOP) & ~up_lvl_i);
  assign borrow_n_o = ~((cnt_i == '0)  & ~dn_lvl_i);

endmodule

// File: rtl/updown_strobe_counter.sv
module updown_strobe_counter
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter bit          DECADE      = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_up_i,
  input  logic             cnt_dn_i,
  input  logic             load_n_i,
  input  logic             clear_i,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] q_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);

  logic             up_lvl, up_rise;
  logic             dn_lvl, dn_rise;
  step_act_t        act;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nxt;

  updn_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_up_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (cnt_up_i),
    .level_o  (up_lvl),
    .rise_o   (up_rise)
  );

  updn_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_dn_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (cnt_dn_i),
    .level_o  (dn_lvl),
    .rise_o   (dn_rise)
  );

  // An edge counts only while the other strobe rests high and is not rising too.
  always_comb begin
    if (up_rise && dn_lvl && !dn_rise)      act = ACT_INC;
    else if (dn_rise && up_lvl && !up_rise) act = ACT_DEC;
    else                                    act = ACT_HOLD;
  end

  updn_next_value #(.WIDTH(WIDTH), .DECADE(DECADE)) u_next (
    .cur_i (cnt_q),
    .act_i (act),
    .nxt_o (cnt_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (!load_n_i) cnt_q <= preset_i;
    else                cnt_q <= cnt_nxt;
  end

  updn_terminal #(.WIDTH(WIDTH), .DECADE(DECADE)) u_term (
    .cnt_i      (cnt_q),
    .up_lvl_i   (up_lvl),
    .dn_lvl_i   (dn_lvl),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o)
  );

  assign q_o = cnt_q;

endmodule

// File: rtl/updn_counter_checker.sv
module updn_counter_checker
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             load_n_i,
  input logic             clear_i,
  input logic [WIDTH-1:0] preset_i,
  input logic [WIDTH-1:0] q_o,
  input logic             carry_n_o,
  input logic             borrow_n_o
);

  localparam logic [WIDTH-1:0] TOP = WIDTH'(top_code(WIDTH, DECADE));

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (q_o == '0));

  p_load_preset_r7: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && !load_n_i) |=> (q_o == $past(preset_i)));

  p_carry_at_top_r9: assert property (@(posedge clk) disable iff (rst)
    !carry_n_o |-> (q_o == TOP));

  p_borrow_at_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !borrow_n_o |-> (q_o == '0));

  // R2 R3: without clear or load the count moves by at most one step or wraps.
  p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && load_n_i) |=>
      (q_o == $past(q_o) || q_o == $past(q_o) + 1'b1 ||
       q_o == $past(q_o) - 1'b1 || q_o == '0 || q_o == TOP));

endmodule

bind updown_strobe_counter updn_counter_checker #(
  .WIDTH  (WIDTH),
  .DECADE (DECADE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_n_i   (load_n_i),
  .clear_i    (clear_i),
  .preset_i   (preset_i),
  .q_o        (q_o),
  .carry_n_o  (carry_n_o),
  .borrow_n_o (borrow_n_o)
);

// File: tb/updown_strobe_counter_test.sv
`timescale 1ns/1ps
module updown_strobe_counter_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up  = 1'b1;
  logic       dn  = 1'b1;
  logic       load_n = 1'b1;
  logic       clr = 1'b0;
  logic [3:0] preset = 4'd0;
  logic [3:0] q_dec, q_bin;
  logic       cy_dec, bw_dec, cy_bin, bw_bin;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  updown_strobe_counter #(.WIDTH(4), .DECADE(1'b1)) uut (
    .clk(clk), .rst(rst), .cnt_up_i(up), .cnt_dn_i(dn), .load_n_i(load_n),
    .clear_i(clr), .preset_i(preset), .q_o(q_dec), .carry_n_o(cy_dec), .borrow_n_o(bw_dec)
  );

  updown_strobe_counter #(.WIDTH(4), .DECADE(1'b0)) uut_bin (
    .clk(clk), .rst(rst), .cnt_up_i(up), .cnt_dn_i(dn), .load_n_i(load_n),
    .clear_i(clr), .preset_i(preset), .q_o(q_bin), .carry_n_o(cy_bin), .borrow_n_o(bw_bin)
  );

  // op: 0 clear, 1 load, 2 up pulse, 3 down pulse; {op, data, exp_decade, exp_binary}
  localparam int NV = 16;
  localparam logic [13:0] VEC [NV] = '{
    {2'd1, 4'd13, 4'd13, 4'd13},  // R6 decade preset above 9
    {2'd2, 4'd0,  4'd0,  4'd14},  // R6 up from 13 -> 0
    {2'd2, 4'd0,  4'd1,  4'd15},  // R2
    {2'd2, 4'd0,  4'd2,  4'd0},   // R5 binary wrap up
    {2'd3, 4'd0,  4'd1,  4'd15},  // R5 binary wrap down
    {2'd3, 4'd0,  4'd0,  4'd14},  // R3
    {2'd3, 4'd0,  4'd9,  4'd13},  // R4 decade wrap down
    {2'd1, 4'd9,  4'd9,  4'd9},   // R7
    {2'd2, 4'd0,  4'd0,  4'd10},  // R4 decade wrap up
    {2'd3, 4'd0,  4'd9,  4'd9},   // R4 R3
    {2'd1, 4'd0,  4'd0,  4'd0},   // R7
    {2'd3, 4'd0,  4'd9,  4'd15},  // R4 R5
    {2'd2, 4'd0,  4'd0,  4'd0},   // R4 R5
    {2'd1, 4'd12, 4'd12, 4'd12},  // R6
    {2'd3, 4'd0,  4'd11, 4'd11},  // R6 down from preset above 9
    {2'd0, 4'd0,  4'd0,  4'd0}    // R8
  };

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up();
    up = 1'b0; wait_n(3);
    up = 1'b1; wait_n(4);
  endtask

  task automatic pulse_dn();
    dn = 1'b0; wait_n(3);
    dn = 1'b1; wait_n(4);
  endtask

  task automatic do_load(input logic [3:0] v);
    preset = v; load_n = 1'b0; wait_n(1);
    load_n = 1'b1; wait_n(1);
  endtask

  initial begin
    wait_n(3);
    check("R1 reset q decade", q_dec, 0);
    check("R1 reset q binary", q_bin, 0);
    rst = 1'b0;
    wait_n(3);
    check("R1 q after release", q_dec, 0);
    check("R1 carry idle", cy_dec, 1);
    check("R1 borrow idle", bw_dec, 1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [3:0] dat, ed, eb;
      {op, dat, ed, eb} = VEC[i];
      case (op)
        2'd0: begin clr = 1'b1; wait_n(1); clr = 1'b0; wait_n(1); end
        2'd1: do_load(dat);
        2'd2: pulse_up();
        default: pulse_dn();
      endcase
      check($sformatf("R2-table step %0d decade", i), q_dec, ed);
      check($sformatf("R3-table step %0d binary", i), q_bin, eb);
    end

    // R2 latency: count changes on the third clock edge after the strobe rises
    do_load(4'd3);
    up = 1'b0; wait_n(3);
    up = 1'b1; wait_n(2);
    check("R2 not yet counted", q_dec, 3);
    wait_n(1);
    check("R2 counted at third edge", q_dec, 4);
    wait_n(3);

    // R9 carry
    do_load(4'd9);
    up = 1'b0; wait_n(3);
    check("R9 decade carry at 9", cy_dec, 0);
    check("R9 binary no carry at 9", cy_bin, 1);
    up = 1'b1; wait_n(4);
    check("R9 carry released", cy_dec, 1);
    do_load(4'd15);
    up = 1'b0; wait_n(3);
    check("R9 binary carry at 15", cy_bin, 0);
    check("R9 decade no carry at 15", cy_dec, 1);
    up = 1'b1; wait_n(4);
    check("R6 decade 15 up -> 0", q_dec, 0);

    // R10 borrow
    do_load(4'd0);
    dn = 1'b0; wait_n(3);
    check("R10 decade borrow at 0", bw_dec, 0);
    check("R10 binary borrow at 0", bw_bin, 0);
    check("R10 carry unaffected", cy_dec, 1);
    dn = 1'b1; wait_n(4);
    check("R10 borrow released", bw_dec, 1);
    do_load(4'd5);
    dn = 1'b0; wait_n(3);
    check("R10 no borrow at 5", bw_dec, 1);
    dn = 1'b1; wait_n(4);

    // R11 up edge while down strobe low is ignored
    do_load(4'd5);
    dn = 1'b0; wait_n(3);
    pulse_up();
    check("R11 up edge ignored", q_dec, 5);
    dn = 1'b1; wait_n(4);
    check("R3 down after ignored edge", q_dec, 4);

    // R11 both strobes rise together
    up = 1'b0; dn = 1'b0; wait_n(3);
    up = 1'b1; dn = 1'b1; wait_n(4);
    check("R11 simultaneous edges ignored", q_dec, 4);

    // R7 load overrides counting
    preset = 4'd7; load_n = 1'b0;
    pulse_up();
    check("R7 load holds preset during count", q_dec, 7);
    load_n = 1'b1; wait_n(1);
    check("R7 preset kept after release", q_dec, 7);

    // R8 clear beats load
    preset = 4'd6; load_n = 1'b0; clr = 1'b1; wait_n(1);
    check("R8 clear over load", q_dec, 0);
    check("R8 clear over load binary", q_bin, 0);
    load_n = 1'b1; clr = 1'b0; wait_n(1);
    check("R8 still zero after clear", q_dec, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule